// File: doc/BRIEF.md
# Evicted-Block Victim Store

This block keeps a handful of blocks that a first-level cache has recently thrown out, so that a short run of conflict misses does not go all the way to the next memory level. Whenever the cache displaces a block, the block's full block address, its data and its dirty flag are written in. Every entry can hold a block from any set of the cache, so the entries work as a small pool of extra ways that all sets share.

When the cache misses, it presents the block address here. The lookup completes within the same cycle. On a hit, the stored block and its dirty flag are handed back so the cache can install the block again, and the entry is released at the next clock edge. On a miss, the request is passed on to the next level in that same cycle. The cache usually needs to displace a block to make room for the one it gets back. That displaced block can be inserted in the same cycle as the hit. It then takes the entry being released, which makes the exchange a swap.

Only evictions fill the store. Demand fills never do. When every entry is occupied, a new insertion overwrites the entry that has been resident longest. If that entry holds modified data, it leaves as a writeback to the next level.

Top module: `victim_store`

## Requirements
- R1: After reset every entry is empty. A lookup misses, and no writeback is raised.
- R2: An inserted block is found by a later lookup of the same block address. The lookup returns hit, the stored data and the stored dirty flag in that same cycle.
- R3: A lookup hit releases the entry at the next edge, so an immediate repeat lookup of that address misses.
- R4: A lookup miss raises the next-level request, carrying the looked-up address, in the same cycle. A hit keeps the request low.
- R5: A lookup does not see a block that is being inserted in the same cycle.
- R6: When all entries are occupied, an insertion overwrites the block inserted earliest. Lookups that miss do not change that order, and a block written into a released entry counts as the newest.
- R7: An overwritten block whose dirty flag is 1 is presented on the writeback outputs in the insertion cycle. An overwritten clean block produces no writeback.
- R8: An insertion in the same cycle as a lookup hit takes the entry being released. It overwrites nothing and raises no writeback, even when the store is full.
- R9: An insertion while an entry is empty fills an empty entry and raises no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Evicted block is presented for insertion |
| ins_addr | input | ADDR_W | Block address (tag and index) of the evicted block |
| ins_data | input | DATA_W | Data of the evicted block |
| ins_dirty | input | 1 | Evicted block holds modified data |
| lk_valid | input | 1 | Cache miss lookup request |
| lk_addr | input | ADDR_W | Block address to look up |
| lk_hit | output | 1 | Lookup found the block |
| lk_data | output | DATA_W | Data of the found block |
| lk_dirty | output | 1 | Dirty flag of the found block |
| nl_req_valid | output | 1 | Lookup missed; fetch from next level |
| nl_req_addr | output | ADDR_W | Address of the next-level fetch |
| wb_valid | output | 1 | Overwritten dirty block must be written back |
| wb_addr | output | ADDR_W | Block address of the writeback |
| wb_data | output | DATA_W | Data of the writeback |

## Verification
The bench builds the store with four entries, a 12-bit block address and 32-bit data. With only four entries, a handful of insertions reach the full state. That lets the oldest-first overwrite, a refill of a released entry, and a swap while full all be exercised in a few dozen cycles. The data word is derived from the address, so every returned or written-back block can be checked against the address it belongs to.

// File: rtl/vstore_pkg.sv
package vstore_pkg;

  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_SWAP  = 2'd1,
    SLOT_FREE  = 2'd2,
    SLOT_EVICT = 2'd3
  } slot_src_e;

  // Isolate the least significant set bit of a vector (up to 64 bits).
  function automatic logic [63:0] lowest_one(input logic [63:0] v);
    return v & (~v + 64'd1);
  endfunction

endpackage

// File: rtl/vstore_match.sv
module vstore_match #(
  parameter int N      = 8,
  parameter int ADDR_W = 26
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              ent_valid,
  input  logic [N-1:0][ADDR_W-1:0]  ent_addr,
  input  logic [ADDR_W-1:0]         key,
  output logic [N-1:0]              match_oh,
  output logic                      any_match
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_oh[g] = ent_valid[g] && (ent_addr[g] == key);
  end

  assign any_match = |match_oh;

  // R2: a block address is resident in at most one entry
  a_r2_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_oh));

endmodule

// File: rtl/vstore_age.sv
module vstore_age #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         touch,
  input  logic [N-1:0] touch_oh,
  output logic [N-1:0] oldest_oh
);

  // older_q[i][j] = 1 : entry i was written before entry j
  logic [N-1:0][N-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          older_q[i][j] <= (i < j);
    end else if (touch) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j) begin
            if (touch_oh[i])      older_q[i][j] <= 1'b0;
            else if (touch_oh[j]) older_q[i][j] <= 1'b1;
          end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      oldest_oh[i] = 1'b1;
      for (int j = 0; j < N; j++)
        if (i != j && !older_q[i][j]) oldest_oh[i] = 1'b0;
    end
  end

  // R6: the age order always names exactly one oldest entry
  a_r6_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_oh) == 1);

  // R6: a freshly written entry is never the oldest afterwards (N > 1)
  a_r6_new_not_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && N > 1) |=> ((oldest_oh & $past(touch_oh)) == '0));

endmodule

// File: rtl/vstore_alloc.sv
module vstore_alloc
  import vstore_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ins_valid,
  input  logic         hit,
  input  logic [N-1:0] hit_oh,
  input  logic [N-1:0] ent_valid,
  input  logic [N-1:0] oldest_oh,
  output logic [N-1:0] slot_oh,
  output slot_src_e    slot_src
);

  logic [N-1:0] free_first;

  assign free_first = N'(lowest_one(64'(~ent_valid)));

  always_comb begin
    slot_oh  = '0;
    slot_src = SLOT_NONE;
    if (ins_valid) begin
      if (hit) begin
        slot_oh  = hit_oh;
        slot_src = SLOT_SWAP;
      end else if (!(&ent_valid)) begin
        slot_oh  = free_first;
        slot_src = SLOT_FREE;
      end else begin
        slot_oh  = oldest_oh;
        slot_src = SLOT_EVICT;
      end
    end
  end

  // R9: an insertion selects exactly one entry
  a_r9_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ($countones(slot_oh) == 1));

  // R9: a free-slot pick never lands on an occupied entry
  a_r9_free_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_src == SLOT_FREE) |-> ((slot_oh & ent_valid) == '0));

endmodule

// File: rtl/victim_store.sv
module victim_store
  import vstore_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              ins_dirty,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_dirty,
  output logic              nl_req_valid,
  output logic [ADDR_W-1:0] nl_req_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);

  localparam int N = ENTRIES;

  logic [N-1:0]             valid_q;
  logic [N-1:0]             dirty_q;
  logic [N-1:0][ADDR_W-1:0] addr_q;
  logic [N-1:0][DATA_W-1:0] data_q;

  logic [N-1:0] match_oh;
  logic         any_match;
  logic [N-1:0] hit_oh;
  logic [N-1:0] oldest_oh;
  logic [N-1:0] slot_oh;
  slot_src_e    slot_src;
  logic         evict_ev;

  vstore_match #(.N(N), .ADDR_W(ADDR_W)) match_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_valid (valid_q),
    .ent_addr  (addr_q),
    .key       (lk_addr),
    .match_oh  (match_oh),
    .any_match (any_match)
  );

  assign lk_hit       = lk_valid && any_match;
  assign hit_oh       = lk_valid ? match_oh : '0;
  assign nl_req_valid = lk_valid && !any_match;
  assign nl_req_addr  = lk_addr;

  vstore_age #(.N(N)) age_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (ins_valid),
    .touch_oh  (slot_oh),
    .oldest_oh (oldest_oh)
  );

  vstore_alloc #(.N(N)) alloc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .hit       (lk_hit),
    .hit_oh    (hit_oh),
    .ent_valid (valid_q),
    .oldest_oh (oldest_oh),
    .slot_oh   (slot_oh),
    .slot_src  (slot_src)
  );

  assign evict_ev = (slot_src == SLOT_EVICT);

  // One-hot AND-OR read muxes for the hit path and the writeback path
  always_comb begin
    lk_data  = '0;
    lk_dirty = 1'b0;
    wb_addr  = '0;
    wb_data  = '0;
    wb_valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit_oh[i]) begin
        lk_data  = lk_data | data_q[i];
        lk_dirty = lk_dirty | dirty_q[i];
      end
      if (evict_ev && slot_oh[i]) begin
        wb_addr  = wb_addr | addr_q[i];
        wb_data  = wb_data | data_q[i];
        wb_valid = wb_valid | dirty_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (slot_oh[i]) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= ins_dirty;
        end else if (hit_oh[i]) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++)
      if (slot_oh[i]) begin
        addr_q[i] <= ins_addr;
        data_q[i] <= ins_data;
      end
  end

  // R3: a hit with no insertion shrinks the occupancy by exactly one
  a_r3_hit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !ins_valid) |=> ($countones(valid_q) == $past($countones(valid_q)) - 1));

  // R4: a lookup either hits or forwards, never both or neither
  a_r4_hit_or_forward: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != nl_req_valid));

  // R7: a writeback is only possible while every entry is occupied
  a_r7_wb_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (&valid_q));

  // R8: a swap never causes a writeback and keeps occupancy unchanged
  a_r8_swap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && ins_valid) |-> !wb_valid);
  a_r8_swap_count: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && ins_valid) |=> ($countones(valid_q) == $past($countones(valid_q))));

  // R9: inserting into a non-full store grows occupancy by one
  a_r9_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !lk_hit && !(&valid_q)) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

endmodule

// File: tb/victim_store_tb_top.sv
`timescale 1ns/1ps
module victim_store_tb_top;

  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0;
  logic [AW-1:0] ins_addr = '0;
  logic [DW-1:0] ins_data = '0;
  logic          ins_dirty = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit, lk_dirty, nl_req_valid, wb_valid;
  logic [DW-1:0] lk_data, wb_data;
  logic [AW-1:0] nl_req_addr, wb_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  victim_store #(.ENTRIES(4), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data), .ins_dirty(ins_dirty),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_data(lk_data), .lk_dirty(lk_dirty),
    .nl_req_valid(nl_req_valid), .nl_req_addr(nl_req_addr),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  function automatic logic [DW-1:0] mkd(input logic [AW-1:0] a);
    return {a, 8'hC3, ~a};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs after the falling edge; outputs settle 1 ns later.
  task automatic drive(input bit iv, input logic [AW-1:0] ia, input bit dt,
                       input bit lv, input logic [AW-1:0] la);
    @(negedge clk);
    ins_valid = iv; ins_addr = ia; ins_data = mkd(ia); ins_dirty = dt;
    lk_valid = lv;  lk_addr = la;
    #1;
  endtask

  task automatic expect_hit(input string req, input logic [AW-1:0] a, input bit dt);
    chk({req, " hit"}, 64'(lk_hit), 64'd1);
    chk({req, " data"}, 64'(lk_data), 64'(mkd(a)));
    chk({req, " dirty"}, 64'(lk_dirty), 64'(dt));
    chk({req, " no fwd"}, 64'(nl_req_valid), 64'd0);
  endtask

  task automatic expect_miss(input string req, input logic [AW-1:0] a);
    chk({req, " miss"}, 64'(lk_hit), 64'd0);
    chk({req, " fwd"}, 64'(nl_req_valid), 64'd1);
    chk({req, " fwd addr"}, 64'(nl_req_addr), 64'(a));
  endtask

  task automatic expect_wb(input string req, input bit v, input logic [AW-1:0] a);
    chk({req, " wb valid"}, 64'(wb_valid), 64'(v));
    if (v) begin
      chk({req, " wb addr"}, 64'(wb_addr), 64'(a));
      chk({req, " wb data"}, 64'(wb_data), 64'(mkd(a)));
    end
  endtask

  task automatic scen_reset();
    drive(0, '0, 0, 1, 12'h010);
    expect_miss("R1 empty after reset", 12'h010);
    expect_wb("R1 no wb after reset", 0, '0);
  endtask

  task automatic scen_basic();
    drive(1, 12'h123, 1, 0, '0);
    expect_wb("R9 insert into empty", 0, '0);
    drive(0, '0, 0, 1, 12'h123);
    expect_hit("R2 R4 lookup after insert", 12'h123, 1);
    drive(0, '0, 0, 1, 12'h123);
    expect_miss("R3 entry released", 12'h123);
  endtask

  task automatic scen_bypass();
    drive(1, 12'h3A5, 0, 1, 12'h3A5);
    expect_miss("R5 no same-cycle bypass", 12'h3A5);
    drive(0, '0, 0, 1, 12'h3A5);
    expect_hit("R5 visible next cycle", 12'h3A5, 0);
  endtask

  task automatic scen_fifo();
    // P0 dirty, P1 clean, P2 clean, P3 dirty
    drive(1, 12'h200, 1, 0, '0); expect_wb("R9 fill 0", 0, '0);
    drive(1, 12'h211, 0, 0, '0); expect_wb("R9 fill 1", 0, '0);
    drive(1, 12'h222, 0, 0, '0); expect_wb("R9 fill 2", 0, '0);
    drive(1, 12'h233, 1, 0, '0); expect_wb("R9 fill 3", 0, '0);
    drive(0, '0, 0, 1, 12'h7FF);
    expect_miss("R6 unrelated miss", 12'h7FF);
    drive(1, 12'h244, 1, 0, '0);
    expect_wb("R6 R7 oldest dirty out", 1, 12'h200);
    drive(1, 12'h255, 0, 0, '0);
    expect_wb("R7 clean overwrite silent", 0, '0);
    drive(0, '0, 0, 1, 12'h200); expect_miss("R6 first gone", 12'h200);
    drive(0, '0, 0, 1, 12'h211); expect_miss("R6 second gone", 12'h211);
    drive(0, '0, 0, 1, 12'h222); expect_hit("R2 third kept", 12'h222, 0);
    drive(1, 12'h266, 1, 0, '0);
    expect_wb("R9 refill released entry", 0, '0);
    drive(1, 12'h277, 1, 0, '0);
    expect_wb("R6 refill is newest, P3 out", 1, 12'h233);
    drive(1, 12'h288, 0, 0, '0);
    expect_wb("R6 R7 next oldest out", 1, 12'h244);
    drive(0, '0, 0, 1, 12'h233); expect_miss("R6 P3 gone", 12'h233);
  endtask

  task automatic scen_swap();
    // resident now: 255(clean) 266(dirty) 277(dirty) 288(clean), store full
    drive(1, 12'h0F0, 1, 1, 12'h255);
    expect_hit("R8 swap hit", 12'h255, 0);
    expect_wb("R8 swap no wb", 0, '0);
    drive(0, '0, 0, 1, 12'h0F0); expect_hit("R8 swapped in", 12'h0F0, 1);
    drive(0, '0, 0, 1, 12'h266); expect_hit("R8 266 kept", 12'h266, 1);
    drive(0, '0, 0, 1, 12'h277); expect_hit("R8 277 kept", 12'h277, 1);
    drive(0, '0, 0, 1, 12'h288); expect_hit("R8 288 kept", 12'h288, 0);
    drive(0, '0, 0, 0, '0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    scen_reset();
    scen_basic();
    scen_bypass();
    scen_fifo();
    scen_swap();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule